// File: doc/BRIEF.md
# Flash Erase Status and Suspend Engine

This block follows an embedded erase or program operation inside a parallel NOR flash model and supplies the word a host sees when it reads the device while that operation is busy. A command decoder upstream hands it single-cycle events: sector erase (with a sector number), program start (with the data word), suspend, resume, and a read strobe carrying the addressed sector. The engine holds a mask of sectors waiting to be erased. It runs one down-counter that measures first the sector-collection window, then the erase time, then the program time. On each read it either passes the array word straight through or returns a polling status word. Which one depends on the phase and on whether the addressed sector is in the mask.

When an erase finishes, the engine pulses a completion strobe together with the mask of sectors that the array must fill with ones. Sectors outside that mask are never named, so their contents stay as they were. The window length, erase time and program time are counted in clock cycles and set by parameters.

Top module: `flash_erase_status`

## Requirements
- R1: After reset the engine is idle: `busy_o` is 0, `fill_valid_o` is 0, and `rd_data_o` equals `array_data_i`.
- R2: A sector erase event in the idle phase opens a collection window that lasts exactly WIN_CYC cycles. During the window, status bit 3 reads 0. During the erase phase that follows, bit 3 reads 1.
- R3: A sector erase event during the window adds its sector to the same erase. Sector erase events after the window has closed, including those made while suspended, do not change the mask.
- R4: The erase phase lasts ERASE_CYC cycles, so an erase with no suspension keeps `busy_o` high for WIN_CYC+ERASE_CYC cycles. In the first idle cycle, `fill_valid_o` is high for exactly one cycle and `fill_mask_o` has bit s set for each selected sector s.
- R5: In the window and erase phases, a read of any sector returns a status word with bit 7 at 0, bits 6 and 2 each inverted relative to the previous read, and bits 5, 4, 1 and 0 at 0.
- R6: A suspend event in the window or erase phase freezes the timer. It also freezes bit 6. Reads of sectors in the mask return bit 7 at 0 and bit 2 inverting on each read. Reads of other sectors return `array_data_i` unchanged.
- R7: A resume event while suspended returns to the erase phase with bit 3 at 1 and bits 6 and 2 toggling again. A suspension made in the erase phase lengthens the busy time by the number of cycles from the suspend event through the resume event, inclusive. A suspension made in the window restarts a full ERASE_CYC erase after the resume.
- R8: A program event in the idle phase keeps `busy_o` high for PROG_CYC cycles. Reads during that time return bit 7 as the complement of bit 7 of the programmed data and bit 6 inverting per read. A program completion does not raise `fill_valid_o`.
- R9: Once the engine is idle, repeated reads return `array_data_i` with no toggling bits.
- R10: Suspend or resume in the idle phase, and resume or program events during an erase, have no effect on `busy_o`, on the erase duration or on the fill mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_erase_i | input | 1 | Sector erase event |
| erase_sec_i | input | SEC_W | Sector named by the erase event |
| prog_start_i | input | 1 | Program start event |
| prog_data_i | input | DATA_W | Word being programmed |
| suspend_i | input | 1 | Erase suspend event |
| resume_i | input | 1 | Erase resume event |
| rd_i | input | 1 | Read strobe |
| rd_sec_i | input | SEC_W | Sector addressed by the read |
| array_data_i | input | DATA_W | Array word at the read address |
| rd_data_o | output | DATA_W | Word returned to the host |
| busy_o | output | 1 | Operation in progress or suspended |
| fill_valid_o | output | 1 | One-cycle erase completion strobe |
| fill_mask_o | output | NUM_SEC | Sectors to fill with ones |

## Verification
A read result is combinational: the bench samples `rd_data_o` 1 ns after the falling edge on which it raised `rd_i`. The status toggles take effect at the next rising edge, so the following read in the next cycle must show the inverted bits. A command event raised in one cycle acts at the next rising edge. The bench therefore numbers each cycle from the edge that accepted the starting event and computes the cycle in which each phase changes. Bit 3 is expected to switch exactly at cycle WIN_CYC, and `busy_o` to fall, with `fill_valid_o` rising, exactly at cycle WIN_CYC+ERASE_CYC. Any suspended stretch is added to those figures.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_WINDOW = 3'd1,
      PH_ERASE  = 3'd2,
      PH_SUSP   = 3'd3,
      PH_PROG   = 3'd4
   } phase_e;

   // status word bit positions decoded by the host-side polling logic
   localparam int BIT_POLL = 7;
   localparam int BIT_TOG  = 6;
   localparam int BIT_WIN  = 3;
   localparam int BIT_ALT  = 2;
endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (load_i) cnt_o <= load_val_i;
      else if (dec_i)  cnt_o <= cnt_o - 1'b1;
   end

   assign zero_o = (cnt_o == '0);

   // R4: the phase logic never asks for a decrement past zero
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i) |-> (cnt_o != '0));
endmodule

// File: rtl/fes_sector_mask.sv
module fes_sector_mask #(
   parameter int NUM_SEC = 8,
   localparam int SEC_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_i,
   input  logic [SEC_W-1:0]   set_sec_i,
   input  logic               clr_i,
   output logic [NUM_SEC-1:0] mask_o
);
   for (genvar g = 0; g < NUM_SEC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   mask_o[g] <= 1'b0;
         else if (clr_i)                               mask_o[g] <= 1'b0;
         else if (set_i && (set_sec_i == SEC_W'(g)))   mask_o[g] <= 1'b1;
      end
   end

   // R3: an accepted sector event lands in the mask by the next cycle
   p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> (mask_o[$past(set_sec_i)] == 1'b1));
endmodule

// File: rtl/fes_status.sv
module fes_status
   import fes_pkg::*;
#(
   parameter int NUM_SEC = 8,
   parameter int DATA_W  = 8,
   localparam int SEC_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  phase_e             phase_i,
   input  logic               rd_i,
   input  logic [SEC_W-1:0]   rd_sec_i,
   input  logic [NUM_SEC-1:0] mask_i,
   input  logic               win_closed_i,
   input  logic               prog_msb_i,
   input  logic [DATA_W-1:0]  array_i,
   output logic [DATA_W-1:0]  data_o
);
   logic tog6, tog2, sel, erase_run;

   assign sel       = mask_i[rd_sec_i];
   assign erase_run = (phase_i == PH_WINDOW) || (phase_i == PH_ERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog6 <= 1'b0;
         tog2 <= 1'b0;
      end else if (rd_i) begin
         if (erase_run || phase_i == PH_PROG)           tog6 <= ~tog6;
         if (erase_run || (phase_i == PH_SUSP && sel))  tog2 <= ~tog2;
      end
   end

   always_comb begin
      data_o = array_i;
      unique case (phase_i)
         PH_WINDOW, PH_ERASE: begin
            data_o           = '0;
            data_o[BIT_TOG]  = tog6;
            data_o[BIT_WIN]  = win_closed_i;
            data_o[BIT_ALT]  = tog2;
         end
         PH_SUSP: begin
            if (sel) begin
               data_o          = '0;
               data_o[BIT_TOG] = tog6;
               data_o[BIT_ALT] = tog2;
            end
         end
         PH_PROG: begin
            data_o           = '0;
            data_o[BIT_POLL] = ~prog_msb_i;
            data_o[BIT_TOG]  = tog6;
         end
         default: data_o = array_i;
      endcase
   end

   // R6: the bit-6 toggle holds still for as long as the erase is suspended
   p_tog_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_SUSP) |=> (phase_i != PH_SUSP || tog6 == $past(tog6)));

   // R9: no toggling while idle
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_IDLE) |=> ($stable(tog6) && $stable(tog2)));
endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status
   import fes_pkg::*;
#(
   parameter int NUM_SEC   = 8,
   parameter int DATA_W    = 8,
   parameter int WIN_CYC   = 16,
   parameter int ERASE_CYC = 64,
   parameter int PROG_CYC  = 8,
   localparam int SEC_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_erase_i,
   input  logic [SEC_W-1:0]   erase_sec_i,
   input  logic               prog_start_i,
   input  logic [DATA_W-1:0]  prog_data_i,
   input  logic               suspend_i,
   input  logic               resume_i,
   input  logic               rd_i,
   input  logic [SEC_W-1:0]   rd_sec_i,
   input  logic [DATA_W-1:0]  array_data_i,
   output logic [DATA_W-1:0]  rd_data_o,
   output logic               busy_o,
   output logic               fill_valid_o,
   output logic [NUM_SEC-1:0] fill_mask_o
);
   localparam int MAX_AB = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
   localparam int MAX_C  = (MAX_AB > PROG_CYC) ? MAX_AB : PROG_CYC;
   localparam int CNT_W  = $clog2(MAX_C + 1);

   if (NUM_SEC < 2)   begin : g_chk_sec  $error("NUM_SEC must be at least 2");   end
   if (DATA_W < 8)    begin : g_chk_dw   $error("DATA_W must be at least 8");    end
   if (WIN_CYC < 1)   begin : g_chk_win  $error("WIN_CYC must be positive");     end
   if (ERASE_CYC < 1) begin : g_chk_er   $error("ERASE_CYC must be positive");   end
   if (PROG_CYC < 1)  begin : g_chk_pr   $error("PROG_CYC must be positive");    end

   phase_e             phase, phase_nx;
   logic               win_closed, win_closed_nx;
   logic               prog_msb;
   logic               t_load, t_dec, t_zero;
   logic [CNT_W-1:0]   t_val, t_cnt;
   logic               m_set, m_clr;
   logic [NUM_SEC-1:0] mask;

   always_comb begin
      phase_nx      = phase;
      win_closed_nx = win_closed;
      t_load        = 1'b0;
      t_val         = '0;
      t_dec         = 1'b0;
      m_set         = 1'b0;
      m_clr         = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (sec_erase_i) begin
               phase_nx      = PH_WINDOW;
               win_closed_nx = 1'b0;
               t_load        = 1'b1;
               t_val         = CNT_W'(WIN_CYC - 1);
               m_set         = 1'b1;
            end else if (prog_start_i) begin
               phase_nx = PH_PROG;
               t_load   = 1'b1;
               t_val    = CNT_W'(PROG_CYC - 1);
            end
         end
         PH_WINDOW: begin
            if (suspend_i) begin
               phase_nx = PH_SUSP;
            end else begin
               m_set = sec_erase_i;
               if (t_zero) begin
                  phase_nx      = PH_ERASE;
                  win_closed_nx = 1'b1;
                  t_load        = 1'b1;
                  t_val         = CNT_W'(ERASE_CYC - 1);
               end else begin
                  t_dec = 1'b1;
               end
            end
         end
         PH_ERASE: begin
            if (suspend_i) begin
               phase_nx = PH_SUSP;
            end else if (t_zero) begin
               phase_nx = PH_IDLE;
               m_clr    = 1'b1;
            end else begin
               t_dec = 1'b1;
            end
         end
         PH_SUSP: begin
            if (resume_i) begin
               phase_nx = PH_ERASE;
               if (!win_closed) begin
                  win_closed_nx = 1'b1;
                  t_load        = 1'b1;
                  t_val         = CNT_W'(ERASE_CYC - 1);
               end
            end
         end
         PH_PROG: begin
            if (t_zero) phase_nx = PH_IDLE;
            else        t_dec    = 1'b1;
         end
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_IDLE;
         win_closed   <= 1'b0;
         prog_msb     <= 1'b0;
         fill_valid_o <= 1'b0;
         fill_mask_o  <= '0;
      end else begin
         phase        <= phase_nx;
         win_closed   <= win_closed_nx;
         fill_valid_o <= m_clr;
         if (m_clr) fill_mask_o <= mask;
         if (phase == PH_IDLE && !sec_erase_i && prog_start_i)
            prog_msb <= prog_data_i[DATA_W-1];
      end
   end

   assign busy_o = (phase != PH_IDLE);

   fes_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load_i(t_load), .load_val_i(t_val),
      .dec_i(t_dec), .cnt_o(t_cnt), .zero_o(t_zero)
   );

   fes_sector_mask #(.NUM_SEC(NUM_SEC)) i_mask (
      .clk(clk), .rst_n(rst_n), .set_i(m_set), .set_sec_i(erase_sec_i),
      .clr_i(m_clr), .mask_o(mask)
   );

   fes_status #(.NUM_SEC(NUM_SEC), .DATA_W(DATA_W)) i_status (
      .clk(clk), .rst_n(rst_n), .phase_i(phase), .rd_i(rd_i),
      .rd_sec_i(rd_sec_i), .mask_i(mask), .win_closed_i(win_closed),
      .prog_msb_i(prog_msb), .array_i(array_data_i), .data_o(rd_data_o)
   );

   // R4: completion strobe lasts one cycle
   p_fill_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid_o |=> !fill_valid_o);

   // R3: once the window has closed, the mask only changes by completion
   p_mask_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ERASE || phase == PH_SUSP) |=> ($stable(mask) || fill_valid_o));

   // R6: the timer does not move while suspended
   p_timer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SUSP && !resume_i) |=> $stable(t_cnt));

   // R10: the suspended phase is only entered on a suspend event
   p_susp_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_SUSP && !suspend_i) |=> (phase != PH_SUSP));
endmodule

// File: tb/test_flash_erase_status.sv
`timescale 1ns/1ps
module test_flash_erase_status;
   localparam int N = 8;
   localparam int W = 6;
   localparam int E = 20;
   localparam int P = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_erase = 1'b0;
   logic [2:0] erase_sec = '0;
   logic       prog_start = 1'b0;
   logic [7:0] prog_data = '0;
   logic       suspend = 1'b0;
   logic       resume = 1'b0;
   logic       rd = 1'b0;
   logic [2:0] rd_sec = '0;
   logic [7:0] arr;
   logic [7:0] rd_data;
   logic       busy, fill_valid;
   logic [N-1:0] fill_mask;

   int checks = 0;
   int fails = 0;
   int k = 0;
   bit finished = 0;

   assign arr = 8'h5A ^ {5'd0, rd_sec};

   always #2.5 clk = ~clk;

   flash_erase_status #(.NUM_SEC(N), .DATA_W(8), .WIN_CYC(W), .ERASE_CYC(E),
                        .PROG_CYC(P)) i_flash_erase_status (
      .clk(clk), .rst_n(rst_n), .sec_erase_i(sec_erase), .erase_sec_i(erase_sec),
      .prog_start_i(prog_start), .prog_data_i(prog_data), .suspend_i(suspend),
      .resume_i(resume), .rd_i(rd), .rd_sec_i(rd_sec), .array_data_i(arr),
      .rd_data_o(rd_data), .busy_o(busy), .fill_valid_o(fill_valid),
      .fill_mask_o(fill_mask)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      k++;
   endtask

   task automatic rd_word(input int s, output logic [7:0] d);
      rd = 1'b1;
      rd_sec = 3'(s);
      #1 d = rd_data;
      tick();
      rd = 1'b0;
   endtask

   task automatic start_erase(input int s);
      sec_erase = 1'b1; erase_sec = 3'(s);
      tick();
      sec_erase = 1'b0;
      k = 0;
   endtask

   task automatic add_sec(input int s);
      sec_erase = 1'b1; erase_sec = 3'(s);
      tick();
      sec_erase = 1'b0;
   endtask

   task automatic do_susp();
      suspend = 1'b1; tick(); suspend = 1'b0;
   endtask

   task automatic do_resume();
      resume = 1'b1; tick(); resume = 1'b0;
   endtask

   task automatic do_prog(input logic [7:0] v);
      prog_start = 1'b1; prog_data = v;
      tick();
      prog_start = 1'b0;
      k = 0;
   endtask

   task automatic wait_idle();
      while (busy && k < 1000) tick();
   endtask

   initial begin
      #200000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", k, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, d0, d1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      #1;
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(fill_valid == 1'b0, "R1 fill", int'(fill_valid), 0);
      chk(rd_data == arr, "R1 passthru", int'(rd_data), int'(arr));
      @(negedge clk);

      // R2 R4 R5 R9: single-sector erase sweep over every sector
      for (int s = 0; s < N; s++) begin
         logic [7:0] first;
         start_erase(s);
         for (int r = 0; r < W + E; r++) begin
            logic [7:0] exp;
            rd_word((s + r) % N, d);
            if (r == 0) first = d;
            exp = 8'h00;
            exp[6] = first[6] ^ r[0];
            exp[2] = first[2] ^ r[0];
            exp[3] = (r >= W);
            chk(d == exp, (r < W) ? "R2 R5 window status" : "R2 R5 erase status",
                int'(d), int'(exp));
         end
         #1;
         chk(busy == 1'b0, "R4 busy end", int'(busy), 0);
         chk(fill_valid == 1'b1, "R4 fill strobe", int'(fill_valid), 1);
         chk(fill_mask == N'(1 << s), "R4 fill mask", int'(fill_mask), 1 << s);
         tick();
         #1;
         chk(fill_valid == 1'b0, "R4 strobe one cycle", int'(fill_valid), 0);
         rd_word(s, d0);
         rd_word(s, d1);
         chk(d0 == (8'h5A ^ 8'(s)) && d1 == d0, "R9 idle reads", int'(d1), int'(8'h5A ^ 8'(s)));
      end

      // R3: add in window, ignored after window
      start_erase(1);
      add_sec(4);
      while (k < W + 1) tick();
      add_sec(6);
      wait_idle();
      chk(k == W + E, "R3 R4 duration", k, W + E);
      #1 chk(fill_mask == 8'h12, "R3 mask", int'(fill_mask), 8'h12);
      tick();

      // R6 R7: suspend during erase
      begin
         int ks, kr;
         start_erase(2);
         add_sec(5);
         while (k < W + 3) tick();
         ks = k;
         do_susp();
         for (int s = 2; s <= 5; s += 3) begin
            rd_word(s, d0);
            rd_word(s, d1);
            chk(d0[7] == 1'b0 && d1[7] == 1'b0, "R6 suspended bit7", int'(d1), 0);
            chk(d0[6] == d1[6], "R6 bit6 frozen", int'(d1[6]), int'(d0[6]));
            chk(d0[2] != d1[2], "R6 bit2 toggles", int'(d1[2]), int'(~d0[2]));
         end
         rd_word(0, d0);
         rd_word(0, d1);
         chk(d0 == 8'h5A && d1 == 8'h5A, "R6 other sector data", int'(d1), 8'h5A);
         add_sec(7);
         tick();
         kr = k;
         do_resume();
         rd_word(2, d0);
         rd_word(6, d1);
         chk(d0[3] == 1'b1 && d1[3] == 1'b1, "R7 bit3 after resume", int'(d0), 8'h08);
         chk(d0[6] != d1[6] && d0[2] != d1[2], "R7 toggles resume", int'(d1), int'(d0 ^ 8'h44));
         wait_idle();
         chk(k == W + E + (kr - ks + 1), "R7 suspended duration", k, W + E + (kr - ks + 1));
         #1 chk(fill_mask == 8'h24, "R3 R7 mask", int'(fill_mask), 8'h24);
         tick();
      end

      // R6 R7: suspend during window
      begin
         int kr;
         start_erase(3);
         tick(); tick();
         do_susp();
         rd_word(3, d0);
         rd_word(3, d1);
         chk(d0[6] == d1[6] && d0[2] != d1[2], "R6 window suspend", int'(d1), int'(d0 ^ 8'h04));
         add_sec(0);
         kr = k;
         do_resume();
         rd_word(1, d0);
         chk(d0[3] == 1'b1, "R7 bit3 window resume", int'(d0), 8'h08);
         wait_idle();
         chk(k == kr + E + 1, "R7 window suspend duration", k, kr + E + 1);
         #1 chk(fill_mask == 8'h08, "R3 R7 mask window", int'(fill_mask), 8'h08);
         tick();
      end

      // R8: program polling for two data patterns
      for (int t = 0; t < 2; t++) begin
         logic [7:0] v, first;
         v = (t == 0) ? 8'h3C : 8'hA5;
         do_prog(v);
         for (int r = 0; r < P; r++) begin
            rd_word(r, d);
            if (r == 0) first = d;
            chk(d[7] == ~v[7] && d[6] == (first[6] ^ r[0]), "R8 program status",
                int'(d), int'({~v[7], first[6] ^ r[0], 6'd0}));
         end
         #1;
         chk(busy == 1'b0 && fill_valid == 1'b0, "R8 program end", int'({busy, fill_valid}), 0);
         tick();
      end

      // R10: stray events
      do_susp();
      do_resume();
      #1 chk(busy == 1'b0 && rd_data == arr, "R10 idle suspend", int'(busy), 0);
      start_erase(0);
      while (k < W + 2) tick();
      do_resume();
      prog_start = 1'b1; prog_data = 8'h00; tick(); prog_start = 1'b0;
      wait_idle();
      chk(k == W + E, "R10 erase unaffected", k, W + E);
      #1 chk(fill_mask == 8'h01, "R10 mask", int'(fill_mask), 8'h01);
      tick();
      #1 chk(busy == 1'b0, "R10 no program started", int'(busy), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule